// File: doc/BRIEF.md
# SPI Register and Command Slave for a Radio Controller

This block is the host-facing serial port of a radio controller. An external master drives an SPI mode-0 link (clock idle low, data sampled on the rising clock edge, most significant bit first). Every transaction opens with a header byte that carries a read/write flag, a burst flag and a six-bit address. Depending on that header the block performs a single or burst access to a configuration register file, a read of a live status register, a command strobe, or an access to a FIFO port. While the header is shifted in, the block returns a status byte built from the controller's live ready, state and FIFO-level inputs.

The configuration file covers addresses 0x00 to 0x2E and is exported as a flat vector. Addresses 0x30 to 0x3D are shared: with the burst flag set they read a status register supplied by the controller, and with it clear they fire a one-cycle strobe on the matching strobe output. Address 0x30 used as a strobe is the reset command. Address 0x3F is the FIFO port, exported as push and pop handshakes; the FIFO storage is not in this block. The SPI pins are sampled by the system clock, which is assumed to run several times faster than the serial clock and to be fed from already synchronized pins.

Top module: `radio_spi_slave`

## Requirements
- R1: The header byte is decoded MSB first as bit 7 read (1) or write (0), bit 6 burst, bits 5:0 address; a single write (burst 0) to an address in 0x00..0x2E stores the following data byte in that configuration register.
- R2: A single read (bit 7 = 1, burst 0) of 0x00..0x2E returns the register on MISO during the next byte; any further byte of a single access writes nothing and returns the status byte.
- R3: In burst mode the address loads a counter that steps by one after each data byte; once it passes 0x2E it stays at 0x2F, where writes are dropped and reads return 0x00.
- R4: On every header byte MISO carries the status byte: bit 7 = chipRdyN, bits 6:4 = radioState, bits 3:0 = rxCount when the header's bit 7 is 1, txFree when it is 0.
- R5: During a burst write every data byte shifted in returns that same status byte on MISO.
- R6: A read with burst 1 of 0x30..0x3D returns statusIn byte (address − 0x30), where byte i is bits 8i+7:8i; the access never continues, so further bytes return the status byte.
- R7: A header with burst 0 and address 0x30..0x3D (either read/write value) raises strobePulse[address − 0x30] for exactly one clock, in the cycle after the clock edge that samples the eighth header bit; at most one strobe bit is ever high.
- R8: The strobe at 0x30 restores every configuration register i to its default (i·29 mod 256) XOR 0x5A, visible in the same cycle as its strobe pulse.
- R9: Address 0x3F is the FIFO port: each completed data byte of a write raises fifoPush for one clock with that byte on fifoPushData; each completed data byte of a read shows fifoPopData and then raises fifoPop for one clock; bursts repeat on 0x3F without stepping.
- R10: Releasing chip select in the middle of a byte discards the partial byte with no write, push, pop or strobe, and the next transaction starts with a header.
- R11: After reset every configuration register holds its default, MISO is low and no strobe, push or pop is active.
- R12: Headers to 0x2F or 0x3E, and burst-1 writes to 0x30..0x3D, do nothing; their data bytes return the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rstN | input | 1 | Asynchronous active-low reset |
| spiSclk | input | 1 | Serial clock from the master, idle low |
| spiCsN | input | 1 | Active-low chip select |
| spiMosi | input | 1 | Serial data from the master |
| spiMiso | output | 1 | Serial data to the master |
| chipRdyN | input | 1 | Ready flag for status bit 7 (low = ready) |
| radioState | input | 3 | Controller state for status bits 6:4 |
| rxCount | input | 4 | Receive bytes available, status bits 3:0 on reads |
| txFree | input | 4 | Transmit free space, status bits 3:0 on writes |
| statusIn | input | 8·NUM_STROBE | Read-only status register values, byte i at address 0x30+i |
| fifoPopData | input | 8 | Byte at the head of the receive FIFO |
| fifoPush | output | 1 | One-cycle push of fifoPushData into the transmit FIFO |
| fifoPushData | output | 8 | Byte to push |
| fifoPop | output | 1 | One-cycle pop of the receive FIFO |
| strobePulse | output | NUM_STROBE | One-cycle command pulses, bit i for address 0x30+i |
| cfgFlat | output | 8·NUM_CFG | Configuration registers, register i at bits 8i+7:8i |

## Verification
The bench aims at the shared upper address range, sending the same address with burst set and clear, and with the read flag both ways on a strobe; a decoder that looked at the wrong bit would read a status register where a pulse was due or pulse on a status read. Bursts are started near the top of the configuration file so that the sink at 0x2F is reached, which catches a counter that wraps back onto register 0 or onto the FIFO. The status nibble is checked with different rxCount and txFree values for reads and writes, exposing a design that picks the count before the read flag has arrived. A transaction cut off inside a data byte, then read back, shows a design that commits partial bytes.

// File: rtl/rspi_pkg.sv
package rspi_pkg;
  localparam int BYTE_W      = 8;
  localparam int ADDR_W      = 6;
  localparam int STROBE_BASE = 48;
  localparam int FIFO_ADDR   = 63;

  typedef enum logic [2:0] {
    MD_VOID, MD_CFG_WR, MD_CFG_RD, MD_FIFO_WR, MD_FIFO_RD, MD_STAT_RD
  } xferMode_t;

  typedef enum logic [1:0] {
    SRC_STATUS, SRC_CFG, SRC_STAT, SRC_FIFO
  } readSrc_t;

  typedef struct packed {
    logic              cfgWe;
    logic              cfgClear;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] wrData;
    logic              misoLoad;
    logic [2:0]        misoIdx;
    readSrc_t          readSrc;
    logic              rwRead;
  } dpCmd_t;

  function automatic logic [BYTE_W-1:0] cfgDefault(input int idx);
    return BYTE_W'(idx * 29) ^ 8'h5A;
  endfunction
endpackage

// File: rtl/rspi_ctrl.sv
module rspi_ctrl
  import rspi_pkg::*;
#(
  parameter int NUM_CFG    = 47,
  parameter int NUM_STROBE = 14
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  spiSclk,
  input  logic                  spiCsN,
  input  logic                  spiMosi,
  output dpCmd_t                cmd,
  output logic [NUM_STROBE-1:0] strobePulse,
  output logic                  fifoPush,
  output logic [BYTE_W-1:0]     fifoPushData,
  output logic                  fifoPop
);
  localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(NUM_CFG - 1);
  localparam logic [ADDR_W-1:0] STB_LO = ADDR_W'(STROBE_BASE);
  localparam logic [ADDR_W-1:0] STB_HI = ADDR_W'(STROBE_BASE + NUM_STROBE - 1);
  localparam logic [ADDR_W-1:0] FIFO_A = ADDR_W'(FIFO_ADDR);

  logic sclkPrev, csPrev, inHeader, rwBit, burst;
  logic [BYTE_W-2:0] shiftIn;
  logic [2:0] bitCnt;
  logic [ADDR_W-1:0] addrCnt;
  xferMode_t mode, hdrMode;

  logic selected, sclkRise, sclkFall, csFall, byteDone, dataDone;
  logic [BYTE_W-1:0] byteIn;
  logic hdrRw, hdrBurst, hdrInRange, hdrStrobe;
  logic [ADDR_W-1:0] hdrAddr;
  logic [NUM_STROBE-1:0] strobeNext;

  assign selected   = ~spiCsN;
  assign sclkRise   = selected & spiSclk & ~sclkPrev;
  assign sclkFall   = selected & ~spiSclk & sclkPrev;
  assign csFall     = selected & csPrev;
  assign byteIn     = {shiftIn, spiMosi};
  assign byteDone   = sclkRise & (bitCnt == 3'd7);
  assign dataDone   = byteDone & ~inHeader;
  assign hdrRw      = byteIn[7];
  assign hdrBurst   = byteIn[6];
  assign hdrAddr    = byteIn[ADDR_W-1:0];
  assign hdrInRange = (hdrAddr >= STB_LO) && (hdrAddr <= STB_HI);
  assign hdrStrobe  = byteDone & inHeader & ~hdrBurst & hdrInRange;

  for (genvar i = 0; i < NUM_STROBE; i++) begin : gStrobe
    assign strobeNext[i] = hdrStrobe && (hdrAddr == ADDR_W'(STROBE_BASE + i));
  end

  always_comb begin
    if (hdrAddr <= CFG_HI)                hdrMode = hdrRw ? MD_CFG_RD : MD_CFG_WR;
    else if (hdrAddr == FIFO_A)           hdrMode = hdrRw ? MD_FIFO_RD : MD_FIFO_WR;
    else if (hdrInRange && hdrBurst && hdrRw) hdrMode = MD_STAT_RD;
    else                                  hdrMode = MD_VOID;
  end

  always_comb begin
    cmd          = '0;
    cmd.cfgWe    = dataDone && (mode == MD_CFG_WR) && (addrCnt <= CFG_HI);
    cmd.cfgClear = hdrStrobe && (hdrAddr == STB_LO);
    cmd.addr     = addrCnt;
    cmd.wrData   = byteIn;
    cmd.misoLoad = csFall | sclkFall;
    cmd.misoIdx  = 3'd7 - bitCnt;
    cmd.rwRead   = rwBit;
    cmd.readSrc  = SRC_STATUS;
    if (!inHeader) begin
      case (mode)
        MD_CFG_RD:  cmd.readSrc = SRC_CFG;
        MD_STAT_RD: cmd.readSrc = SRC_STAT;
        MD_FIFO_RD: cmd.readSrc = SRC_FIFO;
        default:    cmd.readSrc = SRC_STATUS;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev     <= 1'b0;
      csPrev       <= 1'b1;
      inHeader     <= 1'b1;
      rwBit        <= 1'b0;
      burst        <= 1'b0;
      shiftIn      <= '0;
      bitCnt       <= '0;
      addrCnt      <= '0;
      mode         <= MD_VOID;
      strobePulse  <= '0;
      fifoPush     <= 1'b0;
      fifoPop      <= 1'b0;
      fifoPushData <= '0;
    end else begin
      sclkPrev    <= spiSclk;
      csPrev      <= spiCsN;
      strobePulse <= strobeNext;
      fifoPush    <= dataDone && (mode == MD_FIFO_WR);
      fifoPop     <= dataDone && (mode == MD_FIFO_RD);
      if (dataDone && (mode == MD_FIFO_WR)) fifoPushData <= byteIn;
      if (spiCsN) begin
        bitCnt   <= '0;
        inHeader <= 1'b1;
        mode     <= MD_VOID;
      end else if (sclkRise) begin
        shiftIn <= byteIn[BYTE_W-2:0];
        bitCnt  <= bitCnt + 3'd1;
        if (inHeader && (bitCnt == 3'd0)) rwBit <= spiMosi;
        if (byteDone) begin
          if (inHeader) begin
            inHeader <= 1'b0;
            burst    <= hdrBurst;
            addrCnt  <= hdrAddr;
            mode     <= hdrMode;
          end else if (!burst || (mode == MD_STAT_RD)) begin
            mode <= MD_VOID;
          end else if (((mode == MD_CFG_WR) || (mode == MD_CFG_RD)) && (addrCnt <= CFG_HI)) begin
            addrCnt <= addrCnt + ADDR_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/rspi_datapath.sv
module rspi_datapath
  import rspi_pkg::*;
#(
  parameter int NUM_CFG    = 47,
  parameter int NUM_STROBE = 14
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpCmd_t                       cmd,
  input  logic                         chipRdyN,
  input  logic [2:0]                   radioState,
  input  logic [3:0]                   rxCount,
  input  logic [3:0]                   txFree,
  input  logic [BYTE_W*NUM_STROBE-1:0] statusIn,
  input  logic [BYTE_W-1:0]            fifoPopData,
  output logic                         spiMiso,
  output logic [BYTE_W*NUM_CFG-1:0]    cfgFlat
);
  logic [BYTE_W-1:0] cfgMem [NUM_CFG];
  logic [BYTE_W-1:0] statusByte, cfgRead, statRead, outByte;
  logic misoBit;

  assign statusByte = {chipRdyN, radioState, cmd.rwRead ? rxCount : txFree};

  always_comb begin
    cfgRead = '0;
    for (int i = 0; i < NUM_CFG; i++)
      if (cmd.addr == ADDR_W'(i)) cfgRead = cfgMem[i];
  end

  always_comb begin
    statRead = '0;
    for (int i = 0; i < NUM_STROBE; i++)
      if (cmd.addr == ADDR_W'(STROBE_BASE + i)) statRead = statusIn[i*BYTE_W +: BYTE_W];
  end

  always_comb begin
    case (cmd.readSrc)
      SRC_CFG:  outByte = cfgRead;
      SRC_STAT: outByte = statRead;
      SRC_FIFO: outByte = fifoPopData;
      default:  outByte = statusByte;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CFG; i++) cfgMem[i] <= cfgDefault(i);
    end else if (cmd.cfgClear) begin
      for (int i = 0; i < NUM_CFG; i++) cfgMem[i] <= cfgDefault(i);
    end else if (cmd.cfgWe) begin
      for (int i = 0; i < NUM_CFG; i++)
        if (cmd.addr == ADDR_W'(i)) cfgMem[i] <= cmd.wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             misoBit <= 1'b0;
    else if (cmd.misoLoad) misoBit <= outByte[cmd.misoIdx];
  end

  assign spiMiso = misoBit;

  for (genvar i = 0; i < NUM_CFG; i++) begin : gFlat
    assign cfgFlat[i*BYTE_W +: BYTE_W] = cfgMem[i];
  end
endmodule

// File: rtl/radio_spi_slave.sv
module radio_spi_slave
  import rspi_pkg::*;
#(
  parameter int NUM_CFG    = 47,
  parameter int NUM_STROBE = 14
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         spiSclk,
  input  logic                         spiCsN,
  input  logic                         spiMosi,
  output logic                         spiMiso,
  input  logic                         chipRdyN,
  input  logic [2:0]                   radioState,
  input  logic [3:0]                   rxCount,
  input  logic [3:0]                   txFree,
  input  logic [BYTE_W*NUM_STROBE-1:0] statusIn,
  input  logic [BYTE_W-1:0]            fifoPopData,
  output logic                         fifoPush,
  output logic [BYTE_W-1:0]            fifoPushData,
  output logic                         fifoPop,
  output logic [NUM_STROBE-1:0]        strobePulse,
  output logic [BYTE_W*NUM_CFG-1:0]    cfgFlat
);
  dpCmd_t cmd;

  rspi_ctrl #(.NUM_CFG(NUM_CFG), .NUM_STROBE(NUM_STROBE)) u_ctrl (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .cmd(cmd), .strobePulse(strobePulse), .fifoPush(fifoPush),
    .fifoPushData(fifoPushData), .fifoPop(fifoPop)
  );

  rspi_datapath #(.NUM_CFG(NUM_CFG), .NUM_STROBE(NUM_STROBE)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .chipRdyN(chipRdyN), .radioState(radioState),
    .rxCount(rxCount), .txFree(txFree), .statusIn(statusIn), .fifoPopData(fifoPopData),
    .spiMiso(spiMiso), .cfgFlat(cfgFlat)
  );
endmodule

// File: rtl/rspi_checker.sv
module rspi_checker
  import rspi_pkg::*;
#(
  parameter int NUM_CFG    = 47,
  parameter int NUM_STROBE = 14
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      spiSclk,
  input logic                      spiCsN,
  input logic                      fifoPush,
  input logic                      fifoPop,
  input logic [NUM_STROBE-1:0]     strobePulse,
  input logic [BYTE_W*NUM_CFG-1:0] cfgFlat
);
  assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobePulse));

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobePulse != '0) |=> (strobePulse == '0));

  assert_strobe_after_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobePulse != '0) |-> $past(spiSclk));

  assert_fifo_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoPush && fifoPop));

  assert_push_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    fifoPush |=> !fifoPush);

  assert_pop_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |=> !fifoPop);

  assert_deselect_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |=> (strobePulse == '0 && !fifoPush && !fifoPop && $stable(cfgFlat)));
endmodule

bind radio_spi_slave rspi_checker #(.NUM_CFG(NUM_CFG), .NUM_STROBE(NUM_STROBE)) u_chk (.*);

// File: tb/radio_spi_slave_bench.sv
module radio_spi_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;
  localparam int NCFG = 47;
  localparam int NSTB = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiSclk = 1'b0, spiCsN = 1'b1, spiMosi = 1'b0;
  logic spiMiso;
  logic chipRdyN = 1'b0;
  logic [2:0] radioState = 3'd1;
  logic [3:0] rxCount = 4'd3, txFree = 4'd12;
  logic [8*NSTB-1:0] statusIn;
  logic [7:0] fifoPopData = 8'h00;
  logic fifoPush, fifoPop;
  logic [7:0] fifoPushData;
  logic [NSTB-1:0] strobePulse;
  logic [8*NCFG-1:0] cfgFlat;

  always #(CLK_PERIOD/2) clk = ~clk;

  radio_spi_slave u_radio_spi_slave (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .chipRdyN(chipRdyN), .radioState(radioState), .rxCount(rxCount),
    .txFree(txFree), .statusIn(statusIn), .fifoPopData(fifoPopData), .fifoPush(fifoPush),
    .fifoPushData(fifoPushData), .fifoPop(fifoPop), .strobePulse(strobePulse), .cfgFlat(cfgFlat)
  );

  int vectors = 0, miscompares = 0;
  bit running = 0;
  logic [7:0] mcfg [NCFG];
  logic [NSTB-1:0] expStrobe = '0;
  logic expPush = 0, expPop = 0;
  logic [7:0] expPushData = 0;
  logic [7:0] rxQ[$];
  logic [7:0] txq[$];
  int mMode, mAddr;
  bit mBurst, mRw;

  function automatic logic [7:0] defVal(int i);
    return 8'(i * 29) ^ 8'h5A;
  endfunction
  function automatic logic [7:0] statVal(int i);
    return 8'(i * 17 + 3);
  endfunction
  function automatic logic [7:0] statByte(bit rw);
    return {chipRdyN, radioState, rw ? rxCount : txFree};
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison of pulses and the configuration image
  always @(posedge clk) begin
    #1;
    if (running && rstN) begin
      logic [8*NCFG-1:0] expFlat;
      for (int i = 0; i < NCFG; i++) expFlat[i*8 +: 8] = mcfg[i];
      vectors++;
      if (strobePulse !== expStrobe || fifoPush !== expPush || fifoPop !== expPop ||
          (expPush && fifoPushData !== expPushData) || cfgFlat !== expFlat) begin
        miscompares++;
        $display("FAIL R1 R3 R7 R8 R9 cycle: actual strobe=%h push=%b pop=%b data=%h expected strobe=%h push=%b pop=%b data=%h cfgMatch=%b",
                 strobePulse, fifoPush, fifoPop, fifoPushData, expStrobe, expPush, expPop, expPushData,
                 cfgFlat === expFlat);
      end
      if (fifoPop) begin
        if (rxQ.size() > 0) void'(rxQ.pop_front());
        fifoPopData = (rxQ.size() > 0) ? rxQ[0] : 8'h00;
      end
      expStrobe = '0; expPush = 0; expPop = 0;
    end
  end

  task automatic applyByte(input int k, input logic [7:0] b);
    if (k == 0) begin
      mRw = b[7]; mBurst = b[6]; mAddr = int'(b[5:0]);
      if (mAddr <= 46) mMode = mRw ? 2 : 1;
      else if (mAddr == 63) mMode = mRw ? 4 : 3;
      else if (mAddr >= 48 && mAddr <= 61) begin
        if (mBurst) mMode = mRw ? 5 : 0;
        else begin
          mMode = 0;
          expStrobe[mAddr-48] = 1'b1;
          if (mAddr == 48) for (int i = 0; i < NCFG; i++) mcfg[i] = defVal(i);
        end
      end else mMode = 0;
    end else begin
      case (mMode)
        1: if (mAddr <= 46) mcfg[mAddr] = b;
        3: begin expPush = 1; expPushData = b; end
        4: expPop = 1;
        default: ;
      endcase
      if (!mBurst || mMode == 5) mMode = 0;
      else if ((mMode == 1 || mMode == 2) && mAddr <= 46) mAddr++;
    end
  endtask

  // sends txq; the last byte carries only lastBits bits
  task automatic runXact(input int lastBits, input string req);
    @(negedge clk) spiCsN = 1'b0;
    mMode = 0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < txq.size(); k++) begin
      logic [7:0] expB, got;
      int nb;
      nb = (k == txq.size() - 1) ? lastBits : 8;
      got = 8'h00;
      if (k == 0) expB = statByte(txq[0][7]);
      else case (mMode)
        2: expB = (mAddr <= 46) ? mcfg[mAddr] : 8'h00;
        5: expB = statVal(mAddr - 48);
        4: expB = (rxQ.size() > 0) ? rxQ[0] : 8'h00;
        default: expB = statByte(mRw);
      endcase
      for (int i = 7; i >= 8 - nb; i--) begin
        spiMosi = txq[k][i];
        repeat (HALF) @(negedge clk);
        got[i] = spiMiso;
        spiSclk = 1'b1;
        if (i == 0) applyByte(k, txq[k]);
        repeat (HALF) @(negedge clk);
        spiSclk = 1'b0;
      end
      if (nb == 8) check8(req, got, expB);
    end
    repeat (HALF) @(negedge clk);
    spiCsN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < NSTB; i++) statusIn[i*8 +: 8] = statVal(i);
    for (int i = 0; i < NCFG; i++) mcfg[i] = defVal(i);
    rxQ = {8'h11, 8'h22, 8'h33};
    fifoPopData = 8'h11;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    check8("R11 miso", {7'd0, spiMiso}, 8'h00);
    check8("R11 strobe", 8'(strobePulse), 8'h00);
    for (int i = 0; i < NCFG; i++) check8("R11 cfg", cfgFlat[i*8 +: 8], defVal(i));
    running = 1;

    txq = {8'h05, 8'h3C};                   runXact(8, "R1 R4 single write");
    rxCount = 4'd9;
    txq = {8'h85, 8'h00, 8'h00};            runXact(8, "R2 R4 single read");
    radioState = 3'd5; chipRdyN = 1'b1;
    txq = {8'h6C, 8'hA1, 8'hA2, 8'hA3, 8'hA4}; runXact(8, "R3 R5 burst write past end");
    txq = {8'hEC, 8'h00, 8'h00, 8'h00, 8'h00}; runXact(8, "R3 burst read past end");
    txq = {8'hF2, 8'h00, 8'h00};            runXact(8, "R6 status reg 0x32");
    txq = {8'hFD, 8'h00};                   runXact(8, "R6 status reg 0x3D");
    txq = {8'h35};                          runXact(8, "R7 strobe 0x35");
    txq = {8'hB3};                          runXact(8, "R7 strobe with read flag");
    txq = {8'h71, 8'h00};                   runXact(8, "R12 burst write to status range");
    txq = {8'h30};                          runXact(8, "R8 reset strobe");
    txq = {8'h85, 8'h00};                   runXact(8, "R8 readback default");
    txq = {8'h7F, 8'hC1, 8'hC2, 8'hC3};     runXact(8, "R9 fifo burst push");
    txq = {8'h3F, 8'hD1, 8'hD2};            runXact(8, "R9 fifo single push");
    txq = {8'hFF, 8'h00, 8'h00, 8'h00};     runXact(8, "R9 fifo burst pop");
    txq = {8'h0A, 8'h99};                   runXact(8, "R10 setup write");
    txq = {8'h0A, 8'h77};                   runXact(5, "R10 aborted write");
    txq = {8'h8A, 8'h00};                   runXact(8, "R10 value kept");
    txq = {8'h2F, 8'h55};                   runXact(8, "R12 write 0x2F");
    txq = {8'hAF, 8'h00};                   runXact(8, "R12 read 0x2F");
    txq = {8'hBE, 8'h00};                   runXact(8, "R12 read 0x3E");
    radioState = 3'd2; txFree = 4'd0;
    txq = {8'h40, 8'hE0, 8'hE1};            runXact(8, "R5 burst write from 0");
    txq = {8'h3E, 8'h12};                   runXact(8, "R12 write 0x3E");

    running = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule